// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim and Completion

This block gathers level-sensitive interrupt requests from a parameterized set of sources and spreads them over a small number of hart contexts. Source IDs run from 1 to `NUM_SRC`; ID 0 is reserved as "nothing". Each request is caught in a pending bit. Each source carries one priority value. Each context holds its own enable mask and priority threshold. Per context, the block picks the best eligible source every cycle and raises that context's interrupt line while any source qualifies.

Software services a context with a two-step handshake on one register. A read of the context's claim register returns the winning source ID, clears its pending bit and marks it in service. While the source is in service its request is held off from every context. Writing the same ID back completes it, and a request that is still high becomes pending again. A claim read that returns 0 means nothing is left to serve, so a handler loops on claim until it sees 0.

The register port is a plain word bus: a byte address, write data, write and read strobes, and read data. Read data is valid in the same cycle as the read strobe.

Top module: `irq_hub`

## Requirements
- R1: After reset all priorities, enable bits, thresholds, pending bits and in-service flags are 0. Every register reads 0, every claim read returns 0 and all context interrupt outputs are low.
- R2: The priority of source n (1 to NUM_SRC) is at byte address 4*n and holds PRIO_W bits, which read back zero-extended. Wider write data is truncated to PRIO_W bits. Address 0, which would belong to source 0, is unmapped.
- R3: The enable word w of context c is at byte address 0x2000 + 0x80*c + 4*w, with ceil((NUM_SRC+1)/32) words per context. Source n is bit n mod 32 of word n/32. Bit 0 of word 0 and bits above NUM_SRC always read 0.
- R4: The threshold of context c is at byte address 0x200000 + 0x1000*c, holds PRIO_W bits and is independent per context. That context's claim/complete register is at 0x200000 + 0x1000*c + 4.
- R5: A source is eligible for a context only when it is pending, enabled in that context, and its priority is strictly greater than the context's threshold. A source whose priority equals the threshold is not eligible, and a source of priority 0 is never eligible.
- R6: Output bit c of the context interrupt vector is high, combinationally, whenever some source is eligible for context c. It goes low in the cycle after the claim read that removes the last eligible source.
- R7: A claim read returns the eligible source of highest priority for that context, with the lower ID winning a tie. It returns 0 when no source is eligible. Consecutive claim reads each return the next winner.
- R8: A claim read that returns a nonzero ID clears that source's pending bit and sets it in service. An in-service source does not become pending again while its request stays high. A claim read that returns 0 changes no state.
- R9: A write of an in-service source ID to any context's claim register ends its service. If the request is still high, the source is pending again one cycle after the write.
- R10: A completion write whose value is 0, is greater than NUM_SRC, or names a source that is not in service changes no state.
- R11: A request pulse of one cycle leaves the source pending until it is claimed. A completion then finds the request low and does not make the source pending again.
- R12: Reads of unmapped or misaligned addresses return 0. Writes to them change no register.
- R13: A source enabled in several contexts raises each of them. Once one context claims it, the source is no longer offered to the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, deasserted in step with clk |
| src_req | input | NUM_SRC | Level request of sources 1..NUM_SRC (bit 0 of the vector is source 1) |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, takes effect at the clock edge |
| bus_re | input | 1 | Read strobe; a claim read takes effect at the clock edge |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_re, 0 otherwise |
| ctx_irq | output | NUM_CTX | Interrupt request of each context |

## Verification
A pending or in-service bit that is wrong shows up at once on the context interrupt line, because eligibility is combinational. The next claim read also returns the wrong ID or 0. A lost in-service flag shows as a repeat of an ID that was just claimed while its request is held high. A completion that clears the wrong flag shows one cycle after the write, as a source that comes back too early or never returns. Decoder faults show in the same cycle as a nonzero read of an unmapped address, or as a write that lands in the wrong register and is read back there.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int BUS_W = 32;

  // Register map constants (byte addresses)
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  localparam logic [31:0] THR_OFF    = 32'h0000_0000;
  localparam logic [31:0] CLM_OFF    = 32'h0000_0004;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PRIO,
    ACC_EN,
    ACC_THR,
    ACC_CLAIM
  } acc_kind_e;

  // Decoded register access: idx is a source ID or an enable word index
  typedef struct packed {
    acc_kind_e   kind;
    logic [15:0] idx;
    logic [7:0]  ctx;
  } acc_t;

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);

  localparam int          EN_WORDS  = (NUM_SRC + 32) / 32;
  localparam logic [31:0] PRIO_END  = 32'(4 * (NUM_SRC + 1));
  localparam logic [31:0] EN_END    = EN_BASE + EN_STRIDE * 32'(NUM_CTX);
  localparam logic [31:0] CTX_END   = CTX_BASE + CTX_STRIDE * 32'(NUM_CTX);
  localparam logic [31:0] EN_BYTES  = 32'(4 * EN_WORDS);

  logic [31:0] a;
  logic [31:0] en_off;
  logic [31:0] ctx_off;
  logic [31:0] en_in;
  logic [31:0] page;

  always_comb begin
    a       = 32'(addr);
    en_off  = a - EN_BASE;
    ctx_off = a - CTX_BASE;
    en_in   = en_off % EN_STRIDE;
    page    = ctx_off % CTX_STRIDE;
    acc     = '{kind: ACC_NONE, idx: '0, ctx: '0};
    if (a[1:0] == 2'b00) begin
      if (a >= 32'd4 && a < PRIO_END) begin
        acc.kind = ACC_PRIO;
        acc.idx  = 16'(a >> 2);
      end else if (a >= EN_BASE && a < EN_END) begin
        if (en_in < EN_BYTES) begin
          acc.kind = ACC_EN;
          acc.ctx  = 8'(en_off / EN_STRIDE);
          acc.idx  = 16'(en_in >> 2);
        end
      end else if (a >= CTX_BASE && a < CTX_END) begin
        acc.ctx = 8'(ctx_off / CTX_STRIDE);
        if (page == THR_OFF) begin
          acc.kind = ACC_THR;
        end else if (page == CLM_OFF) begin
          acc.kind = ACC_CLAIM;
        end
      end
    end
  end

endmodule

// File: rtl/irq_hub_gateway.sv
module irq_hub_gateway #(
  parameter int NUM_SRC = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC:1]   req,
  input  logic [NUM_SRC:1]   claim_vec,
  input  logic [NUM_SRC:1]   done_vec,
  output logic [NUM_SRC:1]   pend,
  output logic [NUM_SRC:1]   in_svc
);

  logic [NUM_SRC:1] pend_d;
  logic [NUM_SRC:1] svc_d;
  logic [NUM_SRC:1] ce;

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    // next state of one source's gateway
    always_comb begin
      pend_d[s] = pend[s];
      svc_d[s]  = in_svc[s];
      if (claim_vec[s]) begin
        pend_d[s] = 1'b0;
        svc_d[s]  = 1'b1;
      end else begin
        if (req[s] && !in_svc[s]) pend_d[s] = 1'b1;
        if (done_vec[s])          svc_d[s]  = 1'b0;
      end
      ce[s] = claim_vec[s] | done_vec[s] | (req[s] & ~in_svc[s] & ~pend[s]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[s]   <= 1'b0;
        in_svc[s] <= 1'b0;
      end else if (ce[s]) begin
        pend[s]   <= pend_d[s];
        in_svc[s] <= svc_d[s];
      end
    end
  end

endmodule

// File: rtl/irq_hub_select.sv
module irq_hub_select #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic [NUM_SRC:1]          pend,
  input  logic [NUM_SRC:1]          en,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]         thr,
  output logic [ID_W-1:0]           best_id,
  output logic                      any
);

  logic [NUM_SRC:1] elig;

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_elig
    assign elig[s] = pend[s] & en[s] &
                     (prio_flat[(s-1)*PRIO_W +: PRIO_W] > thr);
  end

  // strict greater-than keeps the lowest ID among equal priorities
  always_comb begin
    logic [PRIO_W-1:0] best_p;
    logic [PRIO_W-1:0] p;
    best_p  = '0;
    best_id = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      p = prio_flat[(s-1)*PRIO_W +: PRIO_W];
      if (elig[s] && p > best_p) begin
        best_p  = p;
        best_id = ID_W'(s);
      end
    end
    any = |elig;
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC:1]   src_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic               bus_we,
  input  logic               bus_re,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic [NUM_CTX-1:0] ctx_irq
);

  localparam int ID_W     = $clog2(NUM_SRC + 1);
  localparam int EN_WORDS = (NUM_SRC + 32) / 32;

  acc_t acc;

  logic [PRIO_W-1:0]         prio_q [NUM_SRC+1];
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC:1]          prio_ce;
  logic [NUM_SRC:1]          en_q   [NUM_CTX];
  logic [NUM_SRC:1]          en_d   [NUM_CTX];
  logic [NUM_CTX-1:0]        en_ce;
  logic [PRIO_W-1:0]         thr_q  [NUM_CTX];
  logic [NUM_CTX-1:0]        thr_ce;
  logic [ID_W-1:0]           best_id [NUM_CTX];
  logic [NUM_SRC:1]          pend;
  logic [NUM_SRC:1]          in_svc;
  logic [NUM_SRC:1]          claim_vec;
  logic [NUM_SRC:1]          done_vec;
  logic                      claim_rd;
  logic                      done_wr;

  irq_hub_decode #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .ADDR_W  (ADDR_W)
  ) u_decode (
    .addr (bus_addr),
    .acc  (acc)
  );

  irq_hub_gateway #(
    .NUM_SRC (NUM_SRC)
  ) u_gateway (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (src_req),
    .claim_vec (claim_vec),
    .done_vec  (done_vec),
    .pend      (pend),
    .in_svc    (in_svc)
  );

  // ---------------- priority registers ----------------
  assign prio_q[0] = '0;

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_prio
    assign prio_ce[s] = bus_we && (acc.kind == ACC_PRIO) && (acc.idx == 16'(s));
    assign prio_flat[(s-1)*PRIO_W +: PRIO_W] = prio_q[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[s] <= '0;
      end else if (prio_ce[s]) begin
        prio_q[s] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end

  // ---------------- per-context state ----------------
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    assign en_ce[c]  = bus_we && (acc.kind == ACC_EN)  && (acc.ctx == 8'(c));
    assign thr_ce[c] = bus_we && (acc.kind == ACC_THR) && (acc.ctx == 8'(c));

    // next enable mask: only bits living in the addressed word change
    always_comb begin
      en_d[c] = en_q[c];
      for (int s = 1; s <= NUM_SRC; s++) begin
        if (acc.idx == 16'(s / 32)) begin
          en_d[c][s] = bus_wdata[s % 32];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[c] <= '0;
      end else if (en_ce[c]) begin
        en_q[c] <= en_d[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q[c] <= '0;
      end else if (thr_ce[c]) begin
        thr_q[c] <= bus_wdata[PRIO_W-1:0];
      end
    end

    irq_hub_select #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ID_W    (ID_W)
    ) u_select (
      .pend      (pend),
      .en        (en_q[c]),
      .prio_flat (prio_flat),
      .thr       (thr_q[c]),
      .best_id   (best_id[c]),
      .any       (ctx_irq[c])
    );
  end

  // ---------------- claim and completion ----------------
  assign claim_rd = bus_re && (acc.kind == ACC_CLAIM);
  assign done_wr  = bus_we && (acc.kind == ACC_CLAIM);

  always_comb begin
    claim_vec = '0;
    done_vec  = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (claim_rd && acc.ctx == 8'(c) && best_id[c] == ID_W'(s)) begin
          claim_vec[s] = 1'b1;
        end
      end
      done_vec[s] = done_wr && (bus_wdata == 32'(s)) && in_svc[s];
    end
  end

  // ---------------- read data ----------------
  always_comb begin
    logic [EN_WORDS*32-1:0] en_full;
    bus_rdata = '0;
    en_full   = '0;
    if (bus_re) begin
      unique case (acc.kind)
        ACC_PRIO: begin
          for (int s = 1; s <= NUM_SRC; s++) begin
            if (acc.idx == 16'(s)) bus_rdata = 32'(prio_q[s]);
          end
        end
        ACC_EN: begin
          for (int c = 0; c < NUM_CTX; c++) begin
            if (acc.ctx == 8'(c)) begin
              en_full[NUM_SRC:1] = en_q[c];
            end
          end
          for (int w = 0; w < EN_WORDS; w++) begin
            if (acc.idx == 16'(w)) bus_rdata = en_full[w*32 +: 32];
          end
        end
        ACC_THR: begin
          for (int c = 0; c < NUM_CTX; c++) begin
            if (acc.ctx == 8'(c)) bus_rdata = 32'(thr_q[c]);
          end
        end
        ACC_CLAIM: begin
          for (int c = 0; c < NUM_CTX; c++) begin
            if (acc.ctx == 8'(c)) bus_rdata = 32'(best_id[c]);
          end
        end
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_re,
  input logic               acc_none,
  input logic [31:0]        bus_rdata,
  input logic [NUM_CTX-1:0] ctx_irq,
  input logic [NUM_SRC:1]   pend,
  input logic [NUM_SRC:1]   in_svc,
  input logic [NUM_SRC:1]   claim_vec,
  input logic [NUM_SRC:1]   done_vec
);

  assert_claim_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_vec != '0) |=>
      (((pend & $past(claim_vec)) == '0) &&
       ((in_svc & $past(claim_vec)) == $past(claim_vec))));

  assert_svc_blocks_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & in_svc) == '0));

  assert_single_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec));

  assert_done_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vec != '0) |=> ((in_svc & $past(done_vec)) == '0));

  assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_irq != '0) |-> (pend != '0));

  assert_unmapped_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && acc_none) |-> (bus_rdata == '0));

endmodule

bind irq_hub irq_hub_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_CTX (NUM_CTX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_re    (bus_re),
  .acc_none  (acc.kind == irq_hub_pkg::ACC_NONE),
  .bus_rdata (bus_rdata),
  .ctx_irq   (ctx_irq),
  .pend      (pend),
  .in_svc    (in_svc),
  .claim_vec (claim_vec),
  .done_vec  (done_vec)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;

  localparam int NSRC = 31;
  localparam int NCTX = 2;
  localparam int AW   = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC:1]   src_req = '0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic            bus_we = 1'b0;
  logic            bus_re = 1'b0;
  logic [31:0]     bus_rdata;
  logic [NCTX-1:0] ctx_irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  irq_hub #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_W(3), .ADDR_W(AW)) u_irq_hub (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
  );

  function automatic logic [AW-1:0] a_prio(int id);
    return AW'(4 * id);
  endfunction
  function automatic logic [AW-1:0] a_en(int c, int w);
    return AW'(32'h2000 + 32'h80 * c + 4 * w);
  endfunction
  function automatic logic [AW-1:0] a_thr(int c);
    return AW'(32'h20_0000 + 32'h1000 * c);
  endfunction
  function automatic logic [AW-1:0] a_clm(int c);
    return AW'(32'h20_0000 + 32'h1000 * c + 4);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_req = '0; bus_we = 1'b0; bus_re = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0; bus_addr = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 irq after reset", 32'(ctx_irq), 0);
    rd(a_prio(1), d);   check("R1 prio reset", d, 0);
    rd(a_en(1, 0), d);  check("R1 enable reset", d, 0);
    rd(a_thr(0), d);    check("R1 threshold reset", d, 0);
    rd(a_clm(0), d);    check("R1 claim reset", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(a_prio(5), 5);              rd(a_prio(5), d);  check("R2 prio readback", d, 5);
    wr(a_prio(3), 32'hFFFF_FFFF);  rd(a_prio(3), d);  check("R2 prio truncated", d, 7);
    wr(a_prio(0), 6);              rd(a_prio(0), d);  check("R2 id0 unmapped", d, 0);
    wr(a_en(0, 0), 32'hFFFF_FFFF); rd(a_en(0, 0), d); check("R3 enable bit0 zero", d, 32'hFFFF_FFFE);
    rd(a_en(1, 0), d);             check("R3 other ctx enable", d, 0);
    wr(a_thr(1), 2);               rd(a_thr(1), d);   check("R4 threshold ctx1", d, 2);
    rd(a_thr(0), d);               check("R4 threshold ctx0 untouched", d, 0);
    wr(AW'(32'h9), 5);             rd(a_prio(2), d);  check("R12 misaligned write ignored", d, 0);
    wr(a_en(1, 1), 32'hFFFF_FFFF); rd(a_en(1, 0), d); check("R12 beyond enable words ignored", d, 0);
    rd(AW'(32'h15), d);            check("R12 misaligned read", d, 0);
    rd(AW'(32'h1000), d);          check("R12 unmapped read", d, 0);
  endtask

  task automatic t_elig();
    logic [31:0] d;
    do_reset();
    wr(a_en(0, 0), (32'd1 << 4) | (32'd1 << 6));
    src_req[4] = 1'b1; src_req[6] = 1'b1;
    @(negedge clk);
    check("R5 priority 0 never fires", 32'(ctx_irq[0]), 0);
    wr(a_prio(4), 2);
    wr(a_thr(0), 2);
    check("R5 priority equal threshold", 32'(ctx_irq[0]), 0);
    rd(a_clm(0), d);  check("R5 claim none eligible", d, 0);
    wr(a_thr(0), 1);
    check("R6 irq when eligible", 32'(ctx_irq[0]), 1);
    rd(a_clm(0), d);  check("R8 empty claim left source intact", d, 4);
  endtask

  task automatic t_order();
    logic [31:0] d;
    do_reset();
    wr(a_prio(2), 3);  wr(a_prio(9), 5);
    wr(a_prio(12), 5); wr(a_prio(20), 1);
    wr(a_en(0, 0), (32'd1 << 2) | (32'd1 << 9) | (32'd1 << 12) | (32'd1 << 20));
    src_req[2] = 1'b1; src_req[9] = 1'b1; src_req[12] = 1'b1; src_req[20] = 1'b1;
    @(negedge clk);
    rd(a_clm(0), d);  check("R7 tie lower id", d, 9);
    rd(a_clm(0), d);  check("R7 second winner", d, 12);
    rd(a_clm(0), d);  check("R7 third winner", d, 2);
    check("R6 irq before last claim", 32'(ctx_irq[0]), 1);
    rd(a_clm(0), d);  check("R7 last winner", d, 20);
    check("R6 irq low after last claim", 32'(ctx_irq[0]), 0);
    rd(a_clm(0), d);  check("R8 held request not re-offered", d, 0);
  endtask

  task automatic t_complete();
    logic [31:0] d;
    do_reset();
    wr(a_prio(7), 1);
    wr(a_en(0, 0), 32'd1 << 7);
    src_req[7] = 1'b1;
    @(negedge clk);
    rd(a_clm(0), d);  check("R7 claim source 7", d, 7);
    wr(a_clm(0), 0);
    wr(a_clm(0), 40);
    wr(a_clm(0), 8);
    repeat (2) @(negedge clk);
    check("R10 bad completions ignored irq", 32'(ctx_irq[0]), 0);
    rd(a_clm(0), d);  check("R10 bad completions ignored claim", d, 0);
    wr(a_clm(1), 7);
    check("R9 not pending at completion", 32'(ctx_irq[0]), 0);
    @(negedge clk);
    check("R9 pending one cycle later", 32'(ctx_irq[0]), 1);
    rd(a_clm(0), d);  check("R9 reclaim", d, 7);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    do_reset();
    wr(a_prio(3), 2);
    wr(a_en(0, 0), 32'd1 << 3);
    @(negedge clk); src_req[3] = 1'b1;
    @(negedge clk); src_req[3] = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 pulse stays pending", 32'(ctx_irq[0]), 1);
    rd(a_clm(0), d);  check("R11 pulse claimed", d, 3);
    wr(a_clm(0), 3);
    repeat (2) @(negedge clk);
    check("R11 no re-pend after low request", 32'(ctx_irq[0]), 0);
    rd(a_clm(0), d);  check("R11 claim empty", d, 0);
  endtask

  task automatic t_ctx();
    logic [31:0] d;
    do_reset();
    wr(a_prio(5), 3); wr(a_prio(6), 1);
    wr(a_en(0, 0), 32'd1 << 5);
    wr(a_en(1, 0), (32'd1 << 5) | (32'd1 << 6));
    src_req[5] = 1'b1; src_req[6] = 1'b1;
    @(negedge clk);
    check("R13 both contexts raised", 32'(ctx_irq), 32'b11);
    rd(a_clm(0), d);  check("R13 ctx0 claims 5", d, 5);
    check("R13 ctx0 drops ctx1 stays", 32'(ctx_irq), 32'b10);
    rd(a_clm(1), d);  check("R13 ctx1 skips claimed source", d, 6);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_elig();
    t_order();
    t_complete();
    t_latch();
    t_ctx();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule